// File: doc/BRIEF.md
# Pluggable Module Identification Reader

This host-side block watches the presence line of a pluggable optical module and, when a module is seated, reads the module's 128-byte identification memory over a two-wire serial bus. The presence line is pulled up on the host and grounded by the module, so a low level means "module present". The block drives the bus clock and data lines as an open-drain master. It asserts a line by pulling it low and otherwise releases it. Data from the module is sampled on a separate input.

The read is a single transaction. It writes the device address, sets the memory pointer to zero, issues a repeated start, and then reads all 128 bytes sequentially. Each byte is placed in a local byte array. While the bytes arrive, the block accumulates an 8-bit sum over the checksummed range and compares it with the stored check byte. A completed read raises a done flag and a checksum-good flag. Any stored byte can then be fetched through a registered read port.

A read can fail in two ways: the module withholds an acknowledge, or the module is pulled out during the transfer. Either failure raises an error flag instead of done. After any finished or failed read, a new read starts only after the module has been seen absent and then present again.

Top module: `modid_reader`

## Requirements
- R1: After reset `rd_done`, `rd_err` and `cks_ok` are low. Whenever `rd_busy` is low, neither `scl_drv_low` nor `sda_drv_low` is asserted.
- R2: A read starts only while `present_n` is low. The line must also have been high since the previous read or since reset. If `present_n` simply stays low after a finished or failed read, no new read starts.
- R3: With `QTR = ceil(CLK_HZ / (4*SCL_HZ))`, every high interval of the bus clock during a read lasts at least `2*QTR` cycles. Successive falling clock edges are at least `4*QTR` cycles apart. With the defaults (250 MHz, 100 kHz) the clock therefore never exceeds 100 kHz.
- R4: One read is framed as follows, with every byte sent MSB first. START, then `{DEV_ADDR,0}` = 0xA0, then 0x00. Next a repeated START and `{DEV_ADDR,1}` = 0xA1. Then 128 data bytes, then STOP. The module acknowledges by holding data low during the ninth clock.
- R5: The master acknowledges data bytes 0 to 126 by holding data low on their ninth clock. It leaves data high (NACK) after byte 127 and then issues STOP.
- R6: After a read, `id_byte` shows the stored byte at `id_addr` one clock after the address is applied. Byte i is the i-th byte the module returned.
- R7: When `rd_done` rises, `cks_ok` is high exactly when the low 8 bits of the sum of bytes 64 to 94 equal byte 95. Bytes outside 64..95 have no effect on it.
- R8: If the module does not acknowledge an address or pointer byte, the block issues STOP. It then ends the read with `rd_err` high and `rd_done` low. `rd_done` and `rd_err` are never high together.
- R9: If `present_n` goes high during a read, both lines are released and `rd_err` is set within 3 clocks.
- R10: `rd_busy` is high for the whole read. `rd_done` and `rd_err` are cleared in the cycle the read begins.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| present_n | input | 1 | Module presence line, low when a module is seated |
| sda_in | input | 1 | Sampled level of the serial data line |
| scl_drv_low | output | 1 | 1 pulls the serial clock line low, 0 releases it |
| sda_drv_low | output | 1 | 1 pulls the serial data line low, 0 releases it |
| id_addr | input | 7 | Byte index for the read port |
| id_byte | output | 8 | Stored identification byte, one clock after `id_addr` |
| rd_busy | output | 1 | A read transaction is in progress |
| rd_done | output | 1 | Last read completed normally |
| rd_err | output | 1 | Last read ended by a missing ACK or a removed module |
| cks_ok | output | 1 | Checksum of the last completed read matched |

## Verification
The main read is exercised against four module images and behaviours:
- A consistent image, which separates correct framing and byte order from shifted or bit-reversed capture.
- An image whose check byte is wrong, which shows the comparison is really performed.
- An image changed only at bytes 63 and 96, which shows the summed range ends where required.
- A module that refuses its address, plus a module removed mid-transfer, which separate the two error paths from a normal finish.

A behavioural bus slave records every byte, start, stop and master acknowledge, so misplaced repeated starts or a missing final NACK show up. Clock high widths and fall-to-fall spacing are measured every cycle.

// File: rtl/modid_pkg.sv
package modid_pkg;

    // Bus primitive issued by the sequencer to the bit engine
    typedef enum logic [1:0] {
        BOP_START,
        BOP_STOP,
        BOP_WR,
        BOP_RD
    } bop_e;

    // Byte-level sequencer states
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_TXB,
        SQ_TXACK,
        SQ_RSTART,
        SQ_RXB,
        SQ_RXACK,
        SQ_STOP
    } sq_e;

    // Line levels, 1 = released (pulled high), 0 = driven low
    typedef struct packed {
        logic scl;
        logic sda;
    } lvl_t;

    localparam lvl_t LVL_FREE = '{scl: 1'b1, sda: 1'b1};

    // Line levels for each quarter phase of a primitive
    function automatic lvl_t op_level(bop_e op, logic [1:0] ph, logic b);
        lvl_t l;
        case (op)
            BOP_START: begin
                l.scl = (ph != 2'd3);
                l.sda = (ph <= 2'd1);
            end
            BOP_STOP: begin
                l.scl = (ph != 2'd0);
                l.sda = (ph >= 2'd2);
            end
            BOP_WR: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = b;
            end
            default: begin
                l.scl = (ph == 2'd1) || (ph == 2'd2);
                l.sda = 1'b1;
            end
        endcase
        return l;
    endfunction

    // Quarter-period count, rounded up so the bus never runs faster than asked
    function automatic int quarter_cycles(int clk_hz, int scl_hz);
        return (clk_hz + 4 * scl_hz - 1) / (4 * scl_hz);
    endfunction

endpackage

// File: rtl/modid_presence.sv
module modid_presence (
    input  logic clk,
    input  logic rst,
    input  logic det_n,
    output logic present,
    output logic start_go
);
    logic s1_q, s2_q, armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= 1'b1;
            s2_q    <= 1'b1;
            armed_q <= 1'b1;
        end else begin
            s1_q <= det_n;
            s2_q <= s1_q;
            if (!present)
                armed_q <= 1'b1;
            else if (start_go)
                armed_q <= 1'b0;
        end
    end

    assign present  = !s2_q;
    assign start_go = present && armed_q;
endmodule

// File: rtl/modid_bitphy.sv
module modid_bitphy
    import modid_pkg::*;
#(
    parameter int QTR = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic abort,
    input  logic cmd_valid,
    input  bop_e cmd_op,
    input  logic cmd_bit,
    input  logic sda_in,
    output logic ready,
    output logic bit_done,
    output logic rx_bit,
    output logic scl_low,
    output logic sda_low
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(QTR - 1);

    logic          active_q;
    bop_e          op_q;
    logic          bit_q;
    logic [1:0]    ph_q;
    logic [CW-1:0] cnt_q;
    logic          sd1_q, sd2_q;
    lvl_t          lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sd1_q <= 1'b1;
            sd2_q <= 1'b1;
        end else begin
            sd1_q <= sda_in;
            sd2_q <= sd1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            active_q <= 1'b0;
            op_q     <= BOP_RD;
            bit_q    <= 1'b1;
            ph_q     <= 2'd0;
            cnt_q    <= '0;
            lvl_q    <= LVL_FREE;
            bit_done <= 1'b0;
            rx_bit   <= 1'b0;
        end else begin
            bit_done <= 1'b0;
            if (!active_q) begin
                if (cmd_valid) begin
                    active_q <= 1'b1;
                    op_q     <= cmd_op;
                    bit_q    <= cmd_bit;
                    ph_q     <= 2'd0;
                    cnt_q    <= '0;
                    lvl_q    <= op_level(cmd_op, 2'd0, cmd_bit);
                end
            end else if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                if (ph_q == 2'd2)
                    rx_bit <= sd2_q;
                if (ph_q == 2'd3) begin
                    active_q <= 1'b0;
                    bit_done <= 1'b1;
                end else begin
                    ph_q  <= ph_q + 2'd1;
                    lvl_q <= op_level(op_q, ph_q + 2'd1, bit_q);
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready   = !active_q;
    assign scl_low = !lvl_q.scl;
    assign sda_low = !lvl_q.sda;
endmodule

// File: rtl/modid_seq.sv
module modid_seq
    import modid_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int NBYTES = 128,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_go,
    input  logic          present,
    input  logic          ready,
    input  logic          bit_done,
    input  logic          rx_bit,
    input  logic          ck_match,
    output logic          cmd_valid,
    output bop_e          cmd_op,
    output logic          cmd_bit,
    output logic          abort,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          busy,
    output logic          done_flag,
    output logic          err_flag,
    output logic          sumok_flag
);
    localparam logic [AW-1:0] LAST   = AW'(NBYTES - 1);
    localparam logic [7:0]    WR_HDR = {DEV_ADDR, 1'b0};
    localparam logic [7:0]    RD_HDR = {DEV_ADDR, 1'b1};

    sq_e           st_q;
    logic          wait_q;
    logic [2:0]    bitc_q;
    logic [7:0]    sh_q;
    logic [1:0]    hdr_q;
    logic [AW-1:0] addr_q;
    logic          errp_q;

    always_comb begin
        cmd_op  = BOP_RD;
        cmd_bit = 1'b1;
        case (st_q)
            SQ_START, SQ_RSTART: cmd_op = BOP_START;
            SQ_TXB: begin
                cmd_op  = BOP_WR;
                cmd_bit = sh_q[7];
            end
            SQ_RXACK: begin
                cmd_op  = BOP_WR;
                cmd_bit = (addr_q == LAST);
            end
            SQ_STOP: cmd_op = BOP_STOP;
            default: ;
        endcase
    end

    assign busy      = (st_q != SQ_IDLE);
    assign abort     = busy && !present;
    assign cmd_valid = busy && present && !wait_q && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= SQ_IDLE;
            wait_q     <= 1'b0;
            bitc_q     <= '0;
            sh_q       <= '0;
            hdr_q      <= '0;
            addr_q     <= '0;
            errp_q     <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            done_flag  <= 1'b0;
            err_flag   <= 1'b0;
            sumok_flag <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (abort) begin
                st_q     <= SQ_IDLE;
                wait_q   <= 1'b0;
                err_flag <= 1'b1;
            end else if (st_q == SQ_IDLE) begin
                if (start_go) begin
                    st_q       <= SQ_START;
                    wait_q     <= 1'b0;
                    hdr_q      <= '0;
                    errp_q     <= 1'b0;
                    done_flag  <= 1'b0;
                    err_flag   <= 1'b0;
                    sumok_flag <= 1'b0;
                end
            end else begin
                if (cmd_valid)
                    wait_q <= 1'b1;
                if (bit_done) begin
                    wait_q <= 1'b0;
                    case (st_q)
                        SQ_START: begin
                            sh_q   <= WR_HDR;
                            bitc_q <= '0;
                            st_q   <= SQ_TXB;
                        end
                        SQ_RSTART: begin
                            sh_q   <= RD_HDR;
                            bitc_q <= '0;
                            st_q   <= SQ_TXB;
                        end
                        SQ_TXB: begin
                            sh_q   <= {sh_q[6:0], 1'b0};
                            bitc_q <= bitc_q + 3'd1;
                            if (bitc_q == 3'd7)
                                st_q <= SQ_TXACK;
                        end
                        SQ_TXACK: begin
                            if (rx_bit) begin
                                errp_q <= 1'b1;
                                st_q   <= SQ_STOP;
                            end else begin
                                case (hdr_q)
                                    2'd0: begin
                                        sh_q   <= 8'h00;
                                        bitc_q <= '0;
                                        hdr_q  <= 2'd1;
                                        st_q   <= SQ_TXB;
                                    end
                                    2'd1: begin
                                        hdr_q <= 2'd2;
                                        st_q  <= SQ_RSTART;
                                    end
                                    default: begin
                                        addr_q <= '0;
                                        bitc_q <= '0;
                                        st_q   <= SQ_RXB;
                                    end
                                endcase
                            end
                        end
                        SQ_RXB: begin
                            sh_q   <= {sh_q[6:0], rx_bit};
                            bitc_q <= bitc_q + 3'd1;
                            if (bitc_q == 3'd7) begin
                                wr_en   <= 1'b1;
                                wr_addr <= addr_q;
                                wr_data <= {sh_q[6:0], rx_bit};
                                st_q    <= SQ_RXACK;
                            end
                        end
                        SQ_RXACK: begin
                            if (addr_q == LAST) begin
                                st_q <= SQ_STOP;
                            end else begin
                                addr_q <= addr_q + 1'b1;
                                bitc_q <= '0;
                                st_q   <= SQ_RXB;
                            end
                        end
                        SQ_STOP: begin
                            st_q <= SQ_IDLE;
                            if (errp_q)
                                err_flag <= 1'b1;
                            else begin
                                done_flag  <= 1'b1;
                                sumok_flag <= ck_match;
                            end
                        end
                        default: st_q <= SQ_IDLE;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/modid_store.sv
module modid_store #(
    parameter int NBYTES = 128,
    parameter int CK_LO = 64,
    parameter int CK_HI = 94,
    parameter int CK_AT = 95,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          ck_match
);
    localparam logic [AW-1:0] LO_A = AW'(CK_LO);
    localparam logic [AW-1:0] HI_A = AW'(CK_HI);

    logic [7:0] mem [NBYTES];
    logic [7:0] acc_q;
    logic       in_rng;

    assign in_rng = (wr_addr >= LO_A) && (wr_addr <= HI_A);

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (wr_en && in_rng)
            acc_q <= acc_q + wr_data;
    end

    assign ck_match = (acc_q == mem[CK_AT]);
endmodule

// File: rtl/modid_reader.sv
module modid_reader
    import modid_pkg::*;
#(
    parameter int CLK_HZ = 250_000_000,
    parameter int SCL_HZ = 100_000,
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int NBYTES = 128,
    parameter int CK_LO = 64,
    parameter int CK_HI = 94,
    parameter int CK_AT = 95,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          present_n,
    input  logic          sda_in,
    output logic          scl_drv_low,
    output logic          sda_drv_low,
    input  logic [AW-1:0] id_addr,
    output logic [7:0]    id_byte,
    output logic          rd_busy,
    output logic          rd_done,
    output logic          rd_err,
    output logic          cks_ok
);
    localparam int QTR = quarter_cycles(CLK_HZ, SCL_HZ);

    logic          present, start_go;
    logic          cmd_valid, cmd_bit, abort;
    bop_e          cmd_op;
    logic          ready, bit_done, rx_bit;
    logic          wr_en, ck_match;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    modid_presence u_pres (
        .clk      (clk),
        .rst      (rst),
        .det_n    (present_n),
        .present  (present),
        .start_go (start_go)
    );

    modid_bitphy #(.QTR(QTR)) u_phy (
        .clk       (clk),
        .rst       (rst),
        .abort     (abort),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_bit   (cmd_bit),
        .sda_in    (sda_in),
        .ready     (ready),
        .bit_done  (bit_done),
        .rx_bit    (rx_bit),
        .scl_low   (scl_drv_low),
        .sda_low   (sda_drv_low)
    );

    modid_seq #(.DEV_ADDR(DEV_ADDR), .NBYTES(NBYTES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_go   (start_go),
        .present    (present),
        .ready      (ready),
        .bit_done   (bit_done),
        .rx_bit     (rx_bit),
        .ck_match   (ck_match),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_bit    (cmd_bit),
        .abort      (abort),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (rd_busy),
        .done_flag  (rd_done),
        .err_flag   (rd_err),
        .sumok_flag (cks_ok)
    );

    modid_store #(
        .NBYTES (NBYTES),
        .CK_LO  (CK_LO),
        .CK_HI  (CK_HI),
        .CK_AT  (CK_AT)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (start_go),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (id_addr),
        .rd_data  (id_byte),
        .ck_match (ck_match)
    );
endmodule

// File: rtl/modid_reader_chk.sv
module modid_reader_chk (
    input logic clk,
    input logic rst,
    input logic pres,
    input logic busy,
    input logic done,
    input logic err,
    input logic scl_low,
    input logic sda_low
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_low && !sda_low));

    // R8
    flag_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

    // R9
    unplug_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !pres) |=> (!busy && err));

    // R2
    start_needs_module_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(pres));

    // R10
    start_clears_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!done && !err));
endmodule

bind modid_reader modid_reader_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pres    (present),
    .busy    (rd_busy),
    .done    (rd_done),
    .err     (rd_err),
    .scl_low (scl_drv_low),
    .sda_low (sda_drv_low)
);

// File: tb/sim_modid_reader.sv
module sim_modid_reader;
    localparam int QTR = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       present_n = 1'b1;
    logic [6:0] id_addr = '0;
    logic [7:0] id_byte;
    logic       scl_drv_low, sda_drv_low, rd_busy, rd_done, rd_err, cks_ok;
    logic       s_low = 1'b0;
    wire        scl_bus = !scl_drv_low;
    wire        sda_bus = !(sda_drv_low || s_low);

    modid_reader #(.CLK_HZ(4_000_000), .SCL_HZ(250_000)) u0 (
        .clk         (clk),
        .rst         (rst),
        .present_n   (present_n),
        .sda_in      (sda_bus),
        .scl_drv_low (scl_drv_low),
        .sda_drv_low (sda_drv_low),
        .id_addr     (id_addr),
        .id_byte     (id_byte),
        .rd_busy     (rd_busy),
        .rd_done     (rd_done),
        .rd_err      (rd_err),
        .cks_ok      (cks_ok)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural module memory / bus slave ----------------
    logic [7:0] image [128];
    logic       nack_addr = 1'b0;
    int  sphase = 0, bitn = 0, ptr = 0;
    bit  first = 0, acking = 0, rd_dir = 0;
    logic [7:0] sh = 0;
    logic [7:0] rxq [$];
    int  starts = 0, starts_at_stop = 0, stops = 0, m_acks = 0, m_nacks = 0, nack_ptr = -1;

    task automatic clear_stats();
        rxq.delete();
        starts = 0; starts_at_stop = 0; stops = 0; m_acks = 0; m_nacks = 0; nack_ptr = -1;
    endtask

    always @(negedge sda_bus) if (scl_bus) begin
        sphase = 1; bitn = 0; first = 1; acking = 0; s_low = 0; starts++;
    end

    always @(posedge sda_bus) if (scl_bus) begin
        starts_at_stop = starts; starts = 0; stops++; sphase = 0; s_low = 0;
    end

    always @(posedge scl_bus) begin
        if (sphase == 1 && bitn < 8) begin
            sh = {sh[6:0], sda_bus}; bitn++;
        end else if (sphase == 2) begin
            if (bitn < 8) bitn++;
            else if (bitn == 8) begin
                if (sda_bus) begin m_nacks++; nack_ptr = ptr; sphase = 3; end
                else begin m_acks++; ptr = (ptr + 1) % 128; bitn = 9; end
            end
        end
    end

    always @(negedge scl_bus) begin
        if (sphase == 1) begin
            if (acking) begin
                acking = 0; bitn = 0;
                if (rd_dir) begin sphase = 2; s_low = !image[ptr][7]; end
                else s_low = 0;
            end else if (bitn == 8) begin
                rxq.push_back(sh);
                if (first) begin
                    first = 0;
                    if (nack_addr || sh[7:1] != 7'h50) begin s_low = 0; sphase = 3; end
                    else begin s_low = 1; acking = 1; rd_dir = sh[0]; end
                end else begin
                    ptr = sh % 128; s_low = 1; acking = 1; rd_dir = 0;
                end
            end
        end else if (sphase == 2) begin
            if (bitn >= 1 && bitn < 8) s_low = !image[ptr][7 - bitn];
            else if (bitn == 8) s_low = 0;
            else if (bitn == 9) begin bitn = 0; s_low = !image[ptr][7]; end
        end
    end

    // ---------------- per-clock bus and idle checks ----------------
    int  cyc = 0, last_rise = 0, last_fall = -1000;
    logic prev_scl = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!rd_busy)
                chk(!scl_drv_low && !sda_drv_low, "R1", "bus released while idle", {scl_drv_low, sda_drv_low}, 0);
            if (prev_scl && !scl_bus && rd_busy) begin
                chk(cyc - last_rise >= 2 * QTR, "R3", "clock high width", cyc - last_rise, 2 * QTR);
                chk(cyc - last_fall >= 4 * QTR, "R3", "fall-to-fall period", cyc - last_fall, 4 * QTR);
            end
        end
        if (!prev_scl && scl_bus) last_rise = cyc;
        if (prev_scl && !scl_bus) last_fall = cyc;
        prev_scl = scl_bus;
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] range_sum();
        logic [7:0] s = 0;
        for (int i = 64; i <= 94; i++) s = s + image[i];
        return s;
    endfunction

    task automatic build_image();
        string vn = "OPTOVEND";
        string pn = "XCVR-SR-01";
        for (int i = 0; i < 128; i++) image[i] = 8'(i) ^ 8'h5A;
        image[0] = 8'h03;
        for (int i = 20; i <= 35; i++) image[i] = (i - 20 < vn.len()) ? vn[i - 20] : 8'h20;
        for (int i = 40; i <= 55; i++) image[i] = (i - 40 < pn.len()) ? pn[i - 40] : 8'h20;
        for (int i = 64; i <= 94; i++) image[i] = 8'(i * 7 + 3);
        image[95] = range_sum();
    endtask

    task automatic run_read();
        int n = 0;
        while (!rd_busy && n < 100) begin @(negedge clk); n++; end
        n = 0;
        while (!((rd_done || rd_err) && !rd_busy) && n < 60000) begin @(negedge clk); n++; end
    endtask

    task automatic unplug(input int cycles);
        present_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic check_port(input string req);
        for (int i = 0; i < 128; i++) begin
            id_addr = 7'(i);
            @(negedge clk);
            chk(id_byte == image[i], req, $sformatf("read port byte %0d", i), id_byte, image[i]);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        build_image();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!rd_done && !rd_err && !cks_ok, "R1", "flags after reset", {rd_done, rd_err, cks_ok}, 0);
        repeat (20) @(negedge clk);
        chk(!rd_busy, "R2", "no read without module", rd_busy, 0);

        // Good image
        clear_stats();
        present_n = 1'b0;
        run_read();
        chk(rd_done && !rd_err, "R10", "good read finishes done", {rd_done, rd_err}, 2);
        chk(cks_ok, "R7", "checksum good image", cks_ok, 1);
        chk(rxq.size() == 3, "R4", "bytes written by master", rxq.size(), 3);
        if (rxq.size() == 3) begin
            chk(rxq[0] == 8'hA0, "R4", "write address byte", rxq[0], 8'hA0);
            chk(rxq[1] == 8'h00, "R4", "pointer byte", rxq[1], 8'h00);
            chk(rxq[2] == 8'hA1, "R4", "read address byte", rxq[2], 8'hA1);
        end
        chk(starts_at_stop == 2, "R4", "starts before stop", starts_at_stop, 2);
        chk(stops == 1, "R4", "one stop", stops, 1);
        chk(m_acks == 127, "R5", "master acks", m_acks, 127);
        chk(m_nacks == 1 && nack_ptr == 127, "R5", "nack on last byte", nack_ptr, 127);
        check_port("R6");

        // Module stays in: no restart
        repeat (300) @(negedge clk);
        chk(!rd_busy && rd_done, "R2", "no restart while module stays", {rd_busy, rd_done}, 1);

        // Corrupted check byte
        unplug(10);
        image[95] = image[95] ^ 8'h01;
        clear_stats();
        present_n = 1'b0;
        run_read();
        chk(rd_done && !cks_ok, "R7", "bad check byte detected", {rd_done, cks_ok}, 2);
        id_addr = 7'd95;
        @(negedge clk);
        chk(id_byte == image[95], "R6", "stored check byte", id_byte, image[95]);

        // Bytes just outside the summed range do not matter
        unplug(10);
        image[95] = range_sum();
        image[63] = image[63] + 8'h11;
        image[96] = image[96] + 8'h22;
        clear_stats();
        present_n = 1'b0;
        run_read();
        chk(rd_done && cks_ok, "R7", "range boundary bytes ignored", {rd_done, cks_ok}, 3);

        // Module refuses its address
        unplug(10);
        nack_addr = 1'b1;
        clear_stats();
        present_n = 1'b0;
        run_read();
        chk(rd_err && !rd_done, "R8", "missing ack gives error", {rd_err, rd_done}, 2);
        chk(stops == 1, "R8", "stop after missing ack", stops, 1);
        repeat (200) @(negedge clk);
        chk(!rd_busy && rd_err, "R2", "no retry while module stays", {rd_busy, rd_err}, 1);

        // Removal during a read
        unplug(10);
        nack_addr = 1'b0;
        clear_stats();
        present_n = 1'b0;
        repeat (3000) @(negedge clk);
        chk(rd_busy && !rd_done && !rd_err, "R10", "busy with flags cleared", {rd_busy, rd_done, rd_err}, 4);
        present_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scl_drv_low && !sda_drv_low, "R9", "lines released after removal", {scl_drv_low, sda_drv_low}, 0);
        chk(rd_err && !rd_busy && !rd_done, "R9", "error after removal", {rd_err, rd_busy, rd_done}, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule